// File: doc/BRIEF.md
# Per-Bit Access Policy Configuration Register Bank

This block holds a small set of configuration registers that software reads and writes over a simple single-cycle bus. The bus carries a request strobe, a read/write flag, a word address, write data and byte enables. Every request is accepted at once, because the bank never applies back-pressure. Exactly one cycle later the bank returns a response strobe with read data. Each register bit follows its own access policy. The policies are plain read/write, read-only, write-once, guarded by a lock, restricted to legal encodings, persistent across hard reset, and persistent with a deferred take-over on a link bring-up pulse.

The bank has two asynchronous active-low resets. The power-good reset is the stronger one and clears everything. The hard reset clears all state except the persistent fields. One byte-wide field takes its reset value from strap pins. Addresses without a register complete normally: reads return zero and writes change nothing. The register contents are also driven out as plain outputs to the logic they configure.

Top module: `cfg_attr_bank`

## Requirements
- R1: Word address 0 bits [7:0] form a read/write mode field. On either reset it loads the strap inputs. A write updates only the bytes whose byte enable is set.
- R2: Word address 0 bits [15:8] read back a constant identifier, default 0x5A, and every write to them is ignored.
- R3: Word address 1 holds four write-once bits at positions 0, 8, 16 and 24, one per byte lane. Each bit takes the first write that reaches it with its lane enabled and then holds until reset. A bit whose lane is disabled is neither changed nor marked as written.
- R4: Word address 6 bit 0 is a write-once lock bit. While it is set, the 16-bit guarded field at word address 2 bits [15:0] (reset value 0x00A5) ignores writes.
- R5: Word address 3 bits [1:0] form a restricted field with reset value 0. A write takes effect only when byte lane 0 is enabled and the written value is legal. By default 0, 1 and 3 are legal and 2 is rejected, leaving the field unchanged.
- R6: Word address 4 bits [7:0] are read/write and persistent: a hard reset leaves them unchanged, and only the power-good reset clears them to 0.
- R7: Word address 5 bits [7:0] are a persistent shadow that software writes and reads back. Bits [15:8] read back the active copy. The active copy and its output load the shadow only in the cycle after a link-init pulse. Both survive hard reset and clear on power-good reset.
- R8: Every request receives a response strobe exactly one cycle later. Reads of addresses 7 and above return zero, writes to them change no register, and read data for a write request is zero.
- R9: A hard reset clears all non-persistent registers, the write-once flags, the lock and the response strobe to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard_n | input | 1 | Hard reset, active low, asynchronous |
| rst_pg_n | input | 1 | Power-good reset, active low, asynchronous |
| strap_i | input | 8 | Reset value of the mode field |
| link_init_i | input | 1 | Link bring-up pulse that activates the deferred field |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| mode_o | output | 8 | Mode field |
| once_o | output | 4 | Write-once bits |
| lock_o | output | 1 | Lock bit |
| guard_o | output | 16 | Guarded field |
| sel_o | output | 2 | Restricted field |
| keep_o | output | 8 | Persistent field |
| link_cfg_o | output | 8 | Active deferred field |

## Verification
The assertions assume that the resets are deasserted away from the clock edge and that the restricted field's reset value is one of the legal encodings. The stability checks rely on no reset of the relevant domain striking between two sampled edges. The bench changes resets, requests and the link pulse only on falling clock edges and holds each reset for whole cycles. It also gives the link pulse and bus writes separate cycles, so the shadow-to-active transfer is seen with no same-cycle race.

// File: rtl/cfg_attr_pkg.sv
package cfg_attr_pkg;

  typedef enum logic [2:0] {
    RS_MODE  = 3'd0,
    RS_ONCE  = 3'd1,
    RS_GUARD = 3'd2,
    RS_SEL   = 3'd3,
    RS_KEEP  = 3'd4,
    RS_LINK  = 3'd5,
    RS_LOCK  = 3'd6,
    RS_NONE  = 3'd7
  } reg_sel_e;

  localparam int unsigned LANE_W = 8;

  function automatic reg_sel_e decode_addr(input logic [7:0] a);
    reg_sel_e r;
    case (a)
      8'd0:    r = RS_MODE;
      8'd1:    r = RS_ONCE;
      8'd2:    r = RS_GUARD;
      8'd3:    r = RS_SEL;
      8'd4:    r = RS_KEEP;
      8'd5:    r = RS_LINK;
      8'd6:    r = RS_LOCK;
      default: r = RS_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfg_once_bits.sv
module cfg_once_bits #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bit_we,
  input  logic [W-1:0] bit_wd,
  output logic [W-1:0] q
);

  logic [W-1:0] done_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i]      <= RST_VAL[i];
        done_q[i] <= 1'b0;
      end else if (bit_we[i] && !done_q[i]) begin
        q[i]      <= bit_wd[i];
        done_q[i] <= 1'b1;
      end
    end
  end

  // R3 / R4: a bit already written never changes again before reset
  assert_once_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q ^ $past(q)) & $past(done_q)) == '0);

  // R3: a bit whose write strobe is low keeps its value
  assert_once_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q ^ $past(q)) & ~$past(bit_we)) == '0);

endmodule

// File: rtl/cfg_guard_field.sv
module cfg_guard_field #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lock_i,
  input  logic [W-1:0] bit_we,
  input  logic [W-1:0] bit_wd,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (!lock_i) begin
      q <= (q & ~bit_we) | (bit_wd & bit_we);
    end
  end

  // R4: while locked the field is frozen
  assert_guard_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(q));

endmodule

// File: rtl/cfg_restrict_field.sv
module cfg_restrict_field #(
  parameter int unsigned W = 2,
  parameter logic [(1<<W)-1:0] LEGAL = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);

  logic legal_wr;
  assign legal_wr = we && LEGAL[wd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (legal_wr) begin
      q <= wd;
    end
  end

  // R5: the field only ever holds a legal encoding
  assert_sel_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    LEGAL[q]);

  // R5: an illegal write leaves the field unchanged
  assert_sel_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !LEGAL[wd]) |=> $stable(q));

endmodule

// File: rtl/cfg_persist_field.sv
module cfg_persist_field #(
  parameter int unsigned W = 8,
  parameter bit DEFER = 1'b0
) (
  input  logic         clk,
  input  logic         pg_n,
  input  logic         link_init_i,
  input  logic [W-1:0] bit_we,
  input  logic [W-1:0] bit_wd,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] active_q
);

  always_ff @(posedge clk or negedge pg_n) begin
    if (!pg_n) begin
      shadow_q <= '0;
    end else begin
      shadow_q <= (shadow_q & ~bit_we) | (bit_wd & bit_we);
    end
  end

  if (DEFER) begin : g_defer
    always_ff @(posedge clk or negedge pg_n) begin
      if (!pg_n) begin
        active_q <= '0;
      end else if (link_init_i) begin
        active_q <= shadow_q;
      end
    end

    // R7: the active copy moves only on a link-init pulse
    assert_link_hold_R7: assert property (@(posedge clk) disable iff (!pg_n)
      !link_init_i |=> $stable(active_q));

    // R7: on a pulse the active copy takes the shadow seen at that edge
    assert_link_take_R7: assert property (@(posedge clk) disable iff (!pg_n)
      link_init_i |=> active_q == $past(shadow_q));
  end else begin : g_direct
    logic unused_link;
    assign unused_link = link_init_i;
    assign active_q = shadow_q;
  end

endmodule

// File: rtl/cfg_attr_bank.sv
module cfg_attr_bank
  import cfg_attr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned STRAP_W  = 8,
  parameter logic [7:0]  ID_VAL   = 8'h5A,
  parameter int unsigned GUARD_W  = 16,
  parameter logic [GUARD_W-1:0] GUARD_RST = 16'h00A5,
  parameter int unsigned SEL_W    = 2,
  parameter logic [(1<<SEL_W)-1:0] SEL_LEGAL = 4'b1011,
  parameter int unsigned KEEP_W   = 8,
  parameter int unsigned LINK_W   = 8
) (
  input  logic                clk,
  input  logic                rst_hard_n,
  input  logic                rst_pg_n,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic                link_init_i,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [STRAP_W-1:0]  mode_o,
  output logic [DATA_W/8-1:0] once_o,
  output logic                lock_o,
  output logic [GUARD_W-1:0]  guard_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic [KEEP_W-1:0]   keep_o,
  output logic [LINK_W-1:0]   link_cfg_o
);

  localparam int unsigned BE_W   = DATA_W / LANE_W;
  localparam int unsigned ONCE_W = BE_W;

  logic rst_any_n;
  assign rst_any_n = rst_hard_n & rst_pg_n;

  // write strobes expanded per bit from the byte enables
  logic [DATA_W-1:0] lane_bits;
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_bits[b*LANE_W +: LANE_W] = {LANE_W{req_be[b]}};
  end

  reg_sel_e          sel_reg;
  logic              wr_go;
  logic [DATA_W-1:0] wr_bits;
  assign sel_reg = decode_addr(8'(req_addr));
  assign wr_go   = req_valid && req_write;
  assign wr_bits = wr_go ? lane_bits : '0;

  function automatic logic [DATA_W-1:0] hit(input reg_sel_e s, input reg_sel_e want,
                                            input logic [DATA_W-1:0] bits);
    return (s == want) ? bits : '0;
  endfunction

  logic [DATA_W-1:0] we_mode, we_once, we_guard, we_sel, we_keep, we_link, we_lock;
  assign we_mode  = hit(sel_reg, RS_MODE,  wr_bits);
  assign we_once  = hit(sel_reg, RS_ONCE,  wr_bits);
  assign we_guard = hit(sel_reg, RS_GUARD, wr_bits);
  assign we_sel   = hit(sel_reg, RS_SEL,   wr_bits);
  assign we_keep  = hit(sel_reg, RS_KEEP,  wr_bits);
  assign we_link  = hit(sel_reg, RS_LINK,  wr_bits);
  assign we_lock  = hit(sel_reg, RS_LOCK,  wr_bits);

  // plain read/write mode field with strap reset value
  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      mode_o <= strap_i;
    end else begin
      mode_o <= (mode_o & ~we_mode[STRAP_W-1:0]) |
                (req_wdata[STRAP_W-1:0] & we_mode[STRAP_W-1:0]);
    end
  end

  // write-once bits, one per byte lane at the lane's lowest bit
  logic [ONCE_W-1:0] once_we, once_wd;
  for (genvar k = 0; k < ONCE_W; k++) begin : g_once_pick
    assign once_we[k] = we_once[k*LANE_W];
    assign once_wd[k] = req_wdata[k*LANE_W];
  end

  cfg_once_bits #(.W(ONCE_W), .RST_VAL('0)) u_once (
    .clk    (clk),
    .rst_n  (rst_any_n),
    .bit_we (once_we),
    .bit_wd (once_wd),
    .q      (once_o)
  );

  cfg_once_bits #(.W(1), .RST_VAL(1'b0)) u_lock (
    .clk    (clk),
    .rst_n  (rst_any_n),
    .bit_we (we_lock[0]),
    .bit_wd (req_wdata[0]),
    .q      (lock_o)
  );

  cfg_guard_field #(.W(GUARD_W), .RST_VAL(GUARD_RST)) u_guard (
    .clk    (clk),
    .rst_n  (rst_any_n),
    .lock_i (lock_o),
    .bit_we (we_guard[GUARD_W-1:0]),
    .bit_wd (req_wdata[GUARD_W-1:0]),
    .q      (guard_o)
  );

  cfg_restrict_field #(.W(SEL_W), .LEGAL(SEL_LEGAL), .RST_VAL('0)) u_sel (
    .clk   (clk),
    .rst_n (rst_any_n),
    .we    (&we_sel[SEL_W-1:0]),
    .wd    (req_wdata[SEL_W-1:0]),
    .q     (sel_o)
  );

  logic [KEEP_W-1:0] keep_shadow;
  cfg_persist_field #(.W(KEEP_W), .DEFER(1'b0)) u_keep (
    .clk         (clk),
    .pg_n        (rst_pg_n),
    .link_init_i (link_init_i),
    .bit_we      (we_keep[KEEP_W-1:0]),
    .bit_wd      (req_wdata[KEEP_W-1:0]),
    .shadow_q    (keep_shadow),
    .active_q    (keep_o)
  );

  logic [LINK_W-1:0] link_shadow;
  cfg_persist_field #(.W(LINK_W), .DEFER(1'b1)) u_link (
    .clk         (clk),
    .pg_n        (rst_pg_n),
    .link_init_i (link_init_i),
    .bit_we      (we_link[LINK_W-1:0]),
    .bit_wd      (req_wdata[LINK_W-1:0]),
    .shadow_q    (link_shadow),
    .active_q    (link_cfg_o)
  );

  // read mux
  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (sel_reg)
      RS_MODE: begin
        rd_word[STRAP_W-1:0] = mode_o;
        rd_word[15:8]        = ID_VAL;
      end
      RS_ONCE: begin
        for (int k = 0; k < ONCE_W; k++) rd_word[k*LANE_W] = once_o[k];
      end
      RS_GUARD: rd_word[GUARD_W-1:0] = guard_o;
      RS_SEL:   rd_word[SEL_W-1:0]   = sel_o;
      RS_KEEP:  rd_word[KEEP_W-1:0]  = keep_o;
      RS_LINK: begin
        rd_word[LINK_W-1:0]      = link_shadow;
        rd_word[8 +: LINK_W]     = link_cfg_o;
      end
      RS_LOCK:  rd_word[0] = lock_o;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^req_wdata;

  // R8: each request answered exactly one cycle later
  assert_rsp_follow_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
    req_valid |=> rsp_valid);
  assert_rsp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
    !req_valid |=> !rsp_valid);
  // R8: unmapped reads return zero
  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
    (req_valid && !req_write && req_addr >= ADDR_W'(7)) |=> rsp_rdata == '0);
  // R2: identifier byte always reads back its constant
  assert_id_const_R2: assert property (@(posedge clk) disable iff (!rst_any_n)
    (req_valid && !req_write && req_addr == '0) |=> rsp_rdata[15:8] == ID_VAL);
  // R6: persistent field only moves on a write to its address
  assert_keep_hold_R6: assert property (@(posedge clk) disable iff (!rst_pg_n)
    !(wr_go && sel_reg == RS_KEEP) |=> $stable(keep_o));

endmodule

// File: tb/cfg_attr_bank_tb.sv
`timescale 1ns/1ps
module cfg_attr_bank_tb;

  logic        clk = 1'b0;
  logic        rst_hard_n = 1'b0;
  logic        rst_pg_n = 1'b0;
  logic [7:0]  strap_i = 8'h3C;
  logic        link_init_i = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  mode_o;
  logic [3:0]  once_o;
  logic        lock_o;
  logic [15:0] guard_o;
  logic [1:0]  sel_o;
  logic [7:0]  keep_o;
  logic [7:0]  link_cfg_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_attr_bank u_dut (
    .clk(clk), .rst_hard_n(rst_hard_n), .rst_pg_n(rst_pg_n), .strap_i(strap_i),
    .link_init_i(link_init_i), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mode_o(mode_o), .once_o(once_o),
    .lock_o(lock_o), .guard_o(guard_o), .sel_o(sel_o), .keep_o(keep_o),
    .link_cfg_o(link_cfg_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_hard_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_hard_n = 1'b1;
  endtask

  task automatic pg_reset();
    @(negedge clk); rst_pg_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_pg_n = 1'b1;
  endtask

  task automatic link_pulse();
    @(negedge clk); link_init_i = 1'b1;
    @(negedge clk); link_init_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    chk("R9 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
    chk("R1 mode strap", {24'b0, mode_o}, 32'h3C);
    chk("R9 once clear", {28'b0, once_o}, 32'h0);
    chk("R9 lock clear", {31'b0, lock_o}, 32'h0);
    chk("R4 guard reset", {16'b0, guard_o}, 32'h00A5);
    chk("R5 sel reset", {30'b0, sel_o}, 32'h0);
    rd(4'd0, d, v);
    chk("R2 id readback", d, 32'h0000_5A3C);
    chk("R8 read valid", {31'b0, v}, 32'h1);
  endtask

  task automatic t_mode();
    logic [31:0] d; logic v;
    wr(4'd0, 32'hFFFF_FF11, 4'b0011);
    chk("R1 mode write", {24'b0, mode_o}, 32'h11);
    rd(4'd0, d, v);
    chk("R2 id ignores write", d, 32'h0000_5A11);
    wr(4'd0, 32'h0000_2222, 4'b0010);
    chk("R1 lane off keeps mode", {24'b0, mode_o}, 32'h11);
  endtask

  task automatic t_once();
    logic [31:0] d; logic v;
    wr(4'd1, 32'hFFFF_FFFF, 4'b0000);
    chk("R3 no lanes no change", {28'b0, once_o}, 32'h0);
    wr(4'd1, 32'h0101_0101, 4'b0001);
    chk("R3 first lane write", {28'b0, once_o}, 32'h1);
    wr(4'd1, 32'h0000_0000, 4'b1111);
    chk("R3 per-bit once", {28'b0, once_o}, 32'h1);
    wr(4'd1, 32'hFFFF_FFFF, 4'b1111);
    chk("R3 all consumed", {28'b0, once_o}, 32'h1);
    rd(4'd1, d, v);
    chk("R3 readback", d, 32'h0000_0001);
    hard_reset();
    chk("R9 once after hard reset", {28'b0, once_o}, 32'h0);
    wr(4'd1, 32'h0101_0101, 4'b1111);
    chk("R9 flags cleared", {28'b0, once_o}, 32'hF);
  endtask

  task automatic t_lock();
    logic [31:0] d; logic v;
    wr(4'd2, 32'hFFFF_1234, 4'b0011);
    chk("R4 guard open", {16'b0, guard_o}, 32'h1234);
    wr(4'd6, 32'h1, 4'b0001);
    chk("R4 lock set", {31'b0, lock_o}, 32'h1);
    wr(4'd2, 32'h0000_BEEF, 4'b1111);
    chk("R4 guard locked", {16'b0, guard_o}, 32'h1234);
    wr(4'd6, 32'h0, 4'b1111);
    chk("R4 lock write-once", {31'b0, lock_o}, 32'h1);
    rd(4'd6, d, v);
    chk("R4 lock readback", d, 32'h1);
  endtask

  task automatic t_sel();
    wr(4'd3, 32'hFFFF_FFF3, 4'b0001);
    chk("R5 legal 3", {30'b0, sel_o}, 32'h3);
    wr(4'd3, 32'h2, 4'b0001);
    chk("R5 reject 2", {30'b0, sel_o}, 32'h3);
    wr(4'd3, 32'h1, 4'b0001);
    chk("R5 legal 1", {30'b0, sel_o}, 32'h1);
    wr(4'd3, 32'h0, 4'b1110);
    chk("R5 lane0 off", {30'b0, sel_o}, 32'h1);
    wr(4'd3, 32'h0, 4'b0001);
    chk("R5 legal 0", {30'b0, sel_o}, 32'h0);
    wr(4'd3, 32'h2, 4'b0001);
    chk("R5 reject 2 from 0", {30'b0, sel_o}, 32'h0);
  endtask

  task automatic t_persist();
    logic [31:0] d; logic v;
    wr(4'd4, 32'h77, 4'b0001);
    chk("R6 keep write", {24'b0, keep_o}, 32'h77);
    wr(4'd5, 32'h42, 4'b0001);
    chk("R7 no pulse no active", {24'b0, link_cfg_o}, 32'h0);
    rd(4'd5, d, v);
    chk("R7 shadow readback", d, 32'h0000_0042);
    link_pulse();
    chk("R7 active after pulse", {24'b0, link_cfg_o}, 32'h42);
    rd(4'd5, d, v);
    chk("R7 both readback", d, 32'h0000_4242);
    strap_i = 8'h81;
    hard_reset();
    chk("R6 keep survives hard", {24'b0, keep_o}, 32'h77);
    chk("R7 active survives hard", {24'b0, link_cfg_o}, 32'h42);
    chk("R9 mode reloads strap", {24'b0, mode_o}, 32'h81);
    chk("R9 lock cleared", {31'b0, lock_o}, 32'h0);
    chk("R9 guard reset", {16'b0, guard_o}, 32'h00A5);
    pg_reset();
    chk("R6 keep cleared by pg", {24'b0, keep_o}, 32'h0);
    chk("R7 active cleared by pg", {24'b0, link_cfg_o}, 32'h0);
    rd(4'd5, d, v);
    chk("R7 shadow cleared by pg", d, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] d; logic v;
    logic [7:0] m0; logic [15:0] g0; logic [7:0] k0;
    wr(4'd0, 32'h99, 4'b0001);
    m0 = mode_o; g0 = guard_o; k0 = keep_o;
    rd(4'd7, d, v);
    chk("R8 rsvd read zero", d, 32'h0);
    chk("R8 rsvd read valid", {31'b0, v}, 32'h1);
    wr(4'd9, 32'hFFFF_FFFF, 4'b1111);
    chk("R8 rsvd write mode", {24'b0, mode_o}, {24'b0, m0});
    chk("R8 rsvd write guard", {16'b0, guard_o}, {16'b0, g0});
    chk("R8 rsvd write keep", {24'b0, keep_o}, {24'b0, k0});
    chk("R8 rsvd write once", {28'b0, once_o}, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd0; req_wdata = 32'h55; req_be = 4'b0001;
    @(negedge clk);
    chk("R8 write rsp valid", {31'b0, rsp_valid}, 32'h1);
    chk("R8 write rdata zero", rsp_rdata, 32'h0);
    req_valid = 1'b0; req_write = 1'b0; req_be = '0;
    @(negedge clk);
    chk("R8 idle no rsp", {31'b0, rsp_valid}, 32'h0);
    rd(4'd15, d, v);
    chk("R8 top addr zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_pg_n = 1'b1; rst_hard_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_once();
    t_lock();
    t_sel();
    t_persist();
    t_reserved();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule